// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

This block is one 32-pin general-purpose I/O port behind a simple word-addressed register bus. For each pin it holds an output value, a direction bit and two pull configuration bits. It samples the pins through a synchronizer, and the synchronized value can be read back. Two write-only alias words set or clear single output bits atomically, so software never needs a read-modify-write on the output register.

Every pin also has an interrupt detector. Three per-pin configuration planes select its mode:

- a sense-kind plane, which chooses edge or level sensing;
- a dual-edge plane;
- a polarity plane.

Together they give rising edge, falling edge, both edges, level high or level low. A detected event sets a sticky status bit, but only on pins whose enable bit is 1. Software acknowledges status by writing ones to an acknowledge word. A single interrupt line is high while any status bit is set whose pin is not masked. Two debounce configuration words are plain storage; the debounce filter itself is not part of this block.

Bus timing:

- Writes take effect on the clock edge where the write strobe is sampled.
- Reads load the read-data register on the edge where the read strobe is sampled.

Top module: `gpio_irq_port`

## Requirements
- R1: `pinOe` equals the direction word (word address 2); a bit of 1 drives that pin as an output, and 0 leaves it an input.
- R2: Reset clears every read/write word to 0. A write to word address 0 loads the output data, which appears on `pinOut` after that edge and reads back unchanged.
- R3: A write to word 4 sets each output bit where the written word has a 1. A write to word 5 clears each such bit. Bits written as 0 keep their value, and reads of words 4 and 5 return 0.
- R4: Word 1 is read-only and returns the pin inputs after a two-flop synchronizer: a pin change before edge k is readable by a read strobe sampled at edge k+2.
- R5: With the sense-kind bit (word 13) at 0, the detector works on edges. A dual-edge bit (word 14) of 1 flags either transition. Otherwise a polarity bit (word 15) of 0 flags rising edges and 1 flags falling edges. Edges compare the synchronized value with its value one cycle earlier.
- R6: With the sense-kind bit at 1, the detector works on levels. A polarity bit of 0 means active-high and 1 means active-low, and status is set again on every cycle the level stays active.
- R7: A status bit (word 9, read-only) is only set for pins whose enable bit (word 8) is 1.
- R8: Writing word 12 clears the status bits where the written word has a 1. Bits written as 0 stay unchanged. A new event on the same pin in the same cycle wins, and the bit stays set.
- R9: `irqOut` is high exactly when some status bit is 1 and its mask bit (word 11, reset 0) is 0.
- R10: Words 6 and 7 drive `pullEn` and `pullSel`. Words 16 and 17 are read/write storage. Reads of unmapped words (3, 10, 18 to 31) return 0. Writes to read-only or unmapped words change nothing.
- R11: `rdData` is loaded on the edge where `rdEn` is sampled, and it holds its value on every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | PIN_W | Write data |
| rdData | output | PIN_W | Registered read data |
| pinIn | input | PIN_W | Pin input levels (asynchronous) |
| pinOut | output | PIN_W | Output data to pads |
| pinOe | output | PIN_W | Output enable per pin |
| pullEn | output | PIN_W | Pull enable per pin |
| pullSel | output | PIN_W | Pull type per pin |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: `PIN_W`=32, `ADDR_W`=5 and `SYNC_STAGES`=2. The full 32-bit width lets the five trigger modes each occupy their own group of pins at the same time, so one status read shows how they interact. A 5-bit word address reaches every unmapped hole (3, 10 and 18 to 31) in addition to the mapped words. The two-stage synchronizer fixes the latency from a pin change to a status bit at a known number of cycles. That known latency lets the bench land an acknowledge write in exactly the cycle of a new event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word addresses; RA_NONE marks reads that return zero.
  typedef enum logic [4:0] {
    RA_OUT  = 5'd0,
    RA_IN   = 5'd1,
    RA_DIR  = 5'd2,
    RA_SET  = 5'd4,
    RA_CLR  = 5'd5,
    RA_PEN  = 5'd6,
    RA_PTY  = 5'd7,
    RA_IEN  = 5'd8,
    RA_STAT = 5'd9,
    RA_MASK = 5'd11,
    RA_ACK  = 5'd12,
    RA_KIND = 5'd13,
    RA_DUAL = 5'd14,
    RA_POL  = 5'd15,
    RA_DBEN = 5'd16,
    RA_DBPS = 5'd17,
    RA_NONE = 5'd31
  } regAddrE;

  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    setOut;
    logic    clrOut;
    logic    wrPullEn;
    logic    wrPullType;
    logic    wrIntEn;
    logic    wrMask;
    logic    ackStat;
    logic    wrKind;
    logic    wrDual;
    logic    wrPol;
    logic    wrDbEn;
    logic    wrDbPre;
    logic    rd;
    regAddrE rdSel;
  } strobeT;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobeT            stb
);

  logic       inRange;
  logic [4:0] idx;

  assign inRange = ((addr >> 5) == '0);
  assign idx     = addr[4:0];

  always_comb begin
    stb       = '0;
    stb.rdSel = RA_NONE;
    stb.rd    = rdEn;
    if (inRange) begin
      case (idx)
        RA_OUT:  begin stb.wrOut      = wrEn; stb.rdSel = RA_OUT;  end
        RA_IN:   begin                        stb.rdSel = RA_IN;   end
        RA_DIR:  begin stb.wrDir      = wrEn; stb.rdSel = RA_DIR;  end
        RA_SET:  begin stb.setOut     = wrEn;                      end
        RA_CLR:  begin stb.clrOut     = wrEn;                      end
        RA_PEN:  begin stb.wrPullEn   = wrEn; stb.rdSel = RA_PEN;  end
        RA_PTY:  begin stb.wrPullType = wrEn; stb.rdSel = RA_PTY;  end
        RA_IEN:  begin stb.wrIntEn    = wrEn; stb.rdSel = RA_IEN;  end
        RA_STAT: begin                        stb.rdSel = RA_STAT; end
        RA_MASK: begin stb.wrMask     = wrEn; stb.rdSel = RA_MASK; end
        RA_ACK:  begin stb.ackStat    = wrEn;                      end
        RA_KIND: begin stb.wrKind     = wrEn; stb.rdSel = RA_KIND; end
        RA_DUAL: begin stb.wrDual     = wrEn; stb.rdSel = RA_DUAL; end
        RA_POL:  begin stb.wrPol      = wrEn; stb.rdSel = RA_POL;  end
        RA_DBEN: begin stb.wrDbEn     = wrEn; stb.rdSel = RA_DBEN; end
        RA_DBPS: begin stb.wrDbPre    = wrEn; stb.rdSel = RA_DBPS; end
        default: begin end
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
  input  logic cur,
  input  logic prev,
  input  logic levelMode,
  input  logic dualEdge,
  input  logic invert,
  output logic hit
);

  always_comb begin
    if (levelMode)     hit = cur ^ invert;
    else if (dualEdge) hit = cur ^ prev;
    else if (invert)   hit = prev & ~cur;
    else               hit = cur & ~prev;
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] rdData,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe,
  output logic [PIN_W-1:0] pullEn,
  output logic [PIN_W-1:0] pullSel,
  output logic             irqOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [PIN_W-1:0] dataOut, dirReg, pullEnReg, pullTypeReg;
  logic [PIN_W-1:0] intEn, intMask, kindReg, dualReg, polReg;
  logic [PIN_W-1:0] dbEnReg, dbPreReg, status;
  logic [SYNC_STAGES-1:0][PIN_W-1:0] syncQ;
  logic [PIN_W-1:0] syncVal, prevVal, rawHit, event_, levelHit;

  assign syncVal = syncQ[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevVal <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevVal <= syncVal;
    end
  end

  for (genvar p = 0; p < PIN_W; p++) begin : g_det
    gpio_irq_detect uDet (
      .cur      (syncVal[p]),
      .prev     (prevVal[p]),
      .levelMode(kindReg[p]),
      .dualEdge (dualReg[p]),
      .invert   (polReg[p]),
      .hit      (rawHit[p])
    );
  end

  assign event_ = rawHit & intEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut     <= '0;
      dirReg      <= '0;
      pullEnReg   <= '0;
      pullTypeReg <= '0;
      intEn       <= '0;
      intMask     <= '0;
      kindReg     <= '0;
      dualReg     <= '0;
      polReg      <= '0;
      dbEnReg     <= '0;
      dbPreReg    <= '0;
    end else begin
      if (stb.wrOut)       dataOut <= wrData;
      else if (stb.setOut) dataOut <= dataOut | wrData;
      else if (stb.clrOut) dataOut <= dataOut & ~wrData;
      if (stb.wrDir)      dirReg      <= wrData;
      if (stb.wrPullEn)   pullEnReg   <= wrData;
      if (stb.wrPullType) pullTypeReg <= wrData;
      if (stb.wrIntEn)    intEn       <= wrData;
      if (stb.wrMask)     intMask     <= wrData;
      if (stb.wrKind)     kindReg     <= wrData;
      if (stb.wrDual)     dualReg     <= wrData;
      if (stb.wrPol)      polReg      <= wrData;
      if (stb.wrDbEn)     dbEnReg     <= wrData;
      if (stb.wrDbPre)    dbPreReg    <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            status <= '0;
    else if (stb.ackStat) status <= (status & ~wrData) | event_;
    else                  status <= status | event_;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (stb.rd) begin
      case (stb.rdSel)
        RA_OUT:  rdData <= dataOut;
        RA_IN:   rdData <= syncVal;
        RA_DIR:  rdData <= dirReg;
        RA_PEN:  rdData <= pullEnReg;
        RA_PTY:  rdData <= pullTypeReg;
        RA_IEN:  rdData <= intEn;
        RA_STAT: rdData <= status;
        RA_MASK: rdData <= intMask;
        RA_KIND: rdData <= kindReg;
        RA_DUAL: rdData <= dualReg;
        RA_POL:  rdData <= polReg;
        RA_DBEN: rdData <= dbEnReg;
        RA_DBPS: rdData <= dbPreReg;
        default: rdData <= '0;
      endcase
    end
  end

  assign pinOut  = dataOut;
  assign pinOe   = dirReg;
  assign pullEn  = pullEnReg;
  assign pullSel = pullTypeReg;
  assign irqOut  = |(status & ~intMask);

  // Independent view of an active level on an enabled level-mode pin.
  assign levelHit = intEn & kindReg & (syncVal ^ polReg);

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOut |=> ((dataOut & $past(wrData)) == $past(wrData)));

  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrOut |=> ((dataOut & $past(wrData)) == '0));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~$past(status) & ~$past(intEn)) == '0));

  // R8
  ack_zero_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackStat |=> (($past(status) & ~$past(wrData) & ~status) == '0));

  // R6
  level_resets_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((status & $past(levelHit)) == $past(levelHit)));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rd |=> $stable(rdData));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [PIN_W-1:0]  wrData,
  output logic [PIN_W-1:0]  rdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic [PIN_W-1:0]  pullEn,
  output logic [PIN_W-1:0]  pullSel,
  output logic              irqOut
);

  strobeT stb;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .stb  (stb)
  );

  gpio_irq_dp #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .pullEn (pullEn),
    .pullSel(pullSel),
    .irqOut (irqOut)
  );

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int PW = 32;
  localparam int AW = 5;
  localparam int SS = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic [AW-1:0] addrD;
  logic          wrEnD, rdEnD;
  logic [PW-1:0] wrDataD, pinInD;
  logic [PW-1:0] rdData, pinOut, pinOe, pullEn, pullSel;
  logic          irqOut;

  gpio_irq_port #(.PIN_W(PW), .ADDR_W(AW), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rstN(rstN), .addr(addrD), .wrEn(wrEnD), .rdEn(rdEnD),
    .wrData(wrDataD), .rdData(rdData), .pinIn(pinInD), .pinOut(pinOut),
    .pinOe(pinOe), .pullEn(pullEn), .pullSel(pullSel), .irqOut(irqOut)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string phaseTag = "R2";

  // Behavioural reference state
  bit [31:0] mOut, mDir, mPe, mPt, mIe, mMask, mKind, mDual, mPol, mDbe, mDbp, mStat, mPrev, mRd;
  bit [31:0] syncQ[$];

  task automatic modelReset();
    {mOut, mDir, mPe, mPt, mIe, mMask, mKind, mDual, mPol, mDbe, mDbp, mStat, mPrev, mRd} = '0;
    syncQ = {};
    for (int s = 0; s < SS; s++) syncQ.push_back(32'h0);
  endtask

  function automatic bit [31:0] readVal(int a);
    case (a)
      0: return mOut;   1: return syncQ[SS-1]; 2: return mDir;
      6: return mPe;    7: return mPt;         8: return mIe;
      9: return mStat;  11: return mMask;      13: return mKind;
      14: return mDual; 15: return mPol;       16: return mDbe;
      17: return mDbp;  default: return 32'h0;
    endcase
  endfunction

  task automatic modelStep();
    bit [31:0] hits = 0;
    bit [31:0] cur = syncQ[SS-1];
    int a = int'(addrD);
    if (rdEnD) mRd = readVal(a);
    for (int i = 0; i < 32; i++) begin
      bit h;
      if (!mIe[i])       h = 0;
      else if (mKind[i]) h = (cur[i] != mPol[i]);
      else if (mDual[i]) h = (cur[i] != mPrev[i]);
      else if (mPol[i])  h = mPrev[i] && !cur[i];
      else               h = cur[i] && !mPrev[i];
      hits[i] = h;
    end
    if (wrEnD && a == 12) mStat = mStat & ~wrDataD;
    mStat = mStat | hits;
    mPrev = cur;
    syncQ.push_front(pinInD);
    void'(syncQ.pop_back());
    if (wrEnD) begin
      case (a)
        0: mOut = wrDataD;  2: mDir = wrDataD;
        4: mOut = mOut | wrDataD;  5: mOut = mOut & ~wrDataD;
        6: mPe = wrDataD;   7: mPt = wrDataD;   8: mIe = wrDataD;
        11: mMask = wrDataD; 13: mKind = wrDataD; 14: mDual = wrDataD;
        15: mPol = wrDataD; 16: mDbe = wrDataD; 17: mDbp = wrDataD;
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R1", "pinOe", pinOe, mDir);
    check(phaseTag, "pinOut", pinOut, mOut);
    check("R10", "pullEn", pullEn, mPe);
    check("R10", "pullSel", pullSel, mPt);
    check("R9", "irqOut", {31'h0, irqOut}, {31'h0, |(mStat & ~mMask)});
    check(phaseTag, "rdData", rdData, mRd);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic busWrite(int a, logic [31:0] d);
    addrD = AW'(a); wrDataD = d; wrEnD = 1'b1;
    tick();
    wrEnD = 1'b0;
  endtask

  task automatic busRead(int a);
    addrD = AW'(a); rdEnD = 1'b1;
    tick();
    rdEnD = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wAddr[12] = '{0, 2, 4, 5, 6, 7, 8, 11, 12, 13, 14, 15};
    rstN = 1'b0; addrD = '0; wrEnD = 0; rdEnD = 0; wrDataD = '0; pinInD = '0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R2: reset values of every word
    phaseTag = "R2";
    compareAll();
    for (int a = 0; a < 18; a++) busRead(a);
    busWrite(0, 32'hA5A5_0F0F);
    busRead(0);

    phaseTag = "R1";
    busWrite(2, 32'hFFFF_0000);
    busRead(2);

    phaseTag = "R3";
    busWrite(4, 32'h0000_00F0);
    busWrite(5, 32'h0F00_0001);
    busRead(0);
    busRead(4);
    busRead(5);

    phaseTag = "R10";
    busWrite(6, 32'h1234_ABCD);
    busWrite(7, 32'h00FF_FF00);
    busWrite(16, 32'hDEAD_BEEF);
    busWrite(17, 32'h0000_0123);
    busWrite(1, 32'hFFFF_FFFF);
    busWrite(9, 32'hFFFF_FFFF);
    busWrite(3, 32'hFFFF_FFFF);
    busWrite(20, 32'hFFFF_FFFF);
    busWrite(31, 32'hFFFF_FFFF);
    for (int a = 0; a < 32; a++) busRead(a);

    phaseTag = "R4";
    pinInD = 32'h1234_5678;
    tick();
    busRead(1);
    busRead(1);

    // R7: events on disabled pins leave status clear
    phaseTag = "R7";
    pinInD = '0; idle(3);
    pinInD = 32'hFFFF_FFFF; idle(3);
    busRead(9);

    // R5: rising on 7:0, falling on 15:8, both on 23:16
    phaseTag = "R5";
    pinInD = '0;
    busWrite(13, 32'h0);
    busWrite(14, 32'h00FF_0000);
    busWrite(15, 32'h0000_FF00);
    busWrite(8, 32'h00FF_FFFF);
    idle(3);
    busWrite(12, 32'hFFFF_FFFF);
    busRead(9);
    pinInD = 32'h00FF_FFFF; idle(4);
    busRead(9);
    busWrite(12, 32'hFFFF_FFFF);
    pinInD = 32'h0; idle(4);
    busRead(9);

    // R6: level high on 27:24, level low on 31:28
    phaseTag = "R6";
    busWrite(13, 32'hFF00_0000);
    busWrite(15, 32'hF000_FF00);
    busWrite(8, 32'hFFFF_FFFF);
    pinInD = 32'h0F00_0000; idle(3);
    busWrite(12, 32'hFFFF_FFFF);
    busRead(9);
    pinInD = 32'hF000_0000; idle(3);
    busWrite(12, 32'hFF00_0000);
    busRead(9);

    // R8: partial acknowledge and same-cycle event
    phaseTag = "R8";
    busWrite(8, 32'h00FF_FFFF);
    busWrite(12, 32'h0000_FF00);
    busRead(9);
    busWrite(12, 32'hFFFF_FFFF);
    pinInD = 32'h0000_00FF;
    tick(); tick();
    busWrite(12, 32'h0000_00FF);
    busRead(9);

    // R9: masking
    phaseTag = "R9";
    busWrite(11, 32'h0000_00FF);
    busRead(9);
    busWrite(11, 32'h0000_007F);
    busWrite(12, 32'h0000_0080);
    idle(2);

    // R11: read data holds while registers change without a read strobe
    phaseTag = "R11";
    busRead(0);
    busWrite(0, 32'h5555_AAAA);
    pinInD = 32'hFFFF_0000;
    idle(4);
    busRead(11);

    phaseTag = "R5";
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 4);
      pinInD = $urandom;
      if (op == 0)      busWrite(wAddr[$urandom % 12], $urandom);
      else if (op == 1) busRead(int'($urandom % 32));
      else if (op == 2) busWrite(12, $urandom);
      else              tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule